// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Resolver

This block gathers eight interrupt request lines, holds them in a request register, and picks the pending request of highest priority. Level 0 ranks first and level 7 last. A mask register can hide any level. An in-service register records which levels the processor is currently handling. The block raises `intr` whenever some unmasked request is allowed to interrupt. The processor takes an interrupt in one of two ways. It can pulse `ack`, or it can arm a poll and then read an encoded status byte. That read does the same work as an acknowledge.

Software talks to the block over a small register port with a one-bit address. Address 1 reaches the mask register for both write and read. Address 0 takes a command word when written. Fields in the command word arm a poll, issue a non-specific end-of-interrupt, select which register the next ordinary read returns, and switch a special mask mode on or off. In special mask mode, in-service bits of higher-priority levels no longer hold off lower levels. A masked level then blocks only itself.

Top module: `irq_resolver`

## Requirements
- R1: After reset, `intr` is low, the request, in-service and mask registers all read 0, and the read select points at the request register.
- R2: Writing address 1 loads the mask register, and reading address 1 returns it. A request whose mask bit is 1 never raises `intr` on its own.
- R3: A cycle with `ack` high sets the in-service bit of the winning request. The winner is the lowest-numbered eligible level. A command write with bit 1 = 1 loads bit 0 as the read select (0 = request register, 1 = in-service register), which an ordinary read of address 0 then returns.
- R4: In normal mode, an eligible request must be unmasked, and no in-service bit may be set at its own level or at any lower-numbered level.
- R5: A command write with bit 6 = 1 sets special mask mode to the value of bit 5. A command write with bit 6 = 0 leaves the mode unchanged.
- R6: In special mask mode, an eligible request only needs to be unmasked and have its own in-service bit clear. In-service bits at other levels do not block it.
- R7: A command write with bit 4 = 1 arms a poll. The next read (`cs` and `rd` high, any address) returns a byte with bit 7 = 1 if a request is eligible, bits 2..0 holding that request's level, and all other bits 0. It also sets that level's in-service bit. When nothing is eligible, the byte is 0.
- R8: The poll is disarmed after one poll read, so the following read of address 0 returns the register chosen by the read select.
- R9: The request register samples `irq_in` at each clock edge with a one-cycle delay. It holds its value while a poll is armed, up to and including the poll-read edge.
- R10: A command write with bit 7 = 1 clears the lowest-numbered set in-service bit. In special mask mode, in-service bits at masked levels are skipped.
- R11: Requests are level sensitive. `intr` falls one cycle after the request inputs drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port select |
| wr | input | 1 | Write strobe, one write per cycle high |
| rd | input | 1 | Read strobe, one read per cycle high |
| addr | input | 1 | 0 = command / status, 1 = mask |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `cs` and `rd` are high, otherwise 0 |
| irq_in | input | 8 | Request lines, bit n is level n |
| ack | input | 1 | Hardware acknowledge pulse |
| intr | output | 1 | Interrupt to the processor |

## Verification
The bench targets where blocking starts and stops. It places an in-service bit between two requests in normal mode, and a design with an off-by-one in the blocking prefix would then raise `intr` for a level that must wait. It switches special mask mode on and off through writes with the enable bit clear, and a decoder that ignored the enable bit would flip blocking behaviour. It changes requests while a poll is armed: a design that failed to freeze would report the wrong level, and one that failed to disarm would return the poll byte again. The end-of-interrupt checks in special mask mode put a masked level in service, so a design that did not skip it would clear the wrong bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // command word field positions
  localparam int CMD_RSEL     = 0;
  localparam int CMD_RSEL_EN  = 1;
  localparam int CMD_POLL     = 4;
  localparam int CMD_SMM_VAL  = 5;
  localparam int CMD_SMM_EN   = 6;
  localparam int CMD_EOI      = 7;

  typedef enum logic {
    RSEL_REQ = 1'b0,
    RSEL_SVC = 1'b1
  } rsel_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 8,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic          valid,
  output logic [LW-1:0] idx
);
  // lowest index wins
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        valid = 1'b1;
        idx   = LW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_elig.sv
module irq_elig #(
  parameter int N = 8
) (
  input  logic [N-1:0] irr,
  input  logic [N-1:0] imr,
  input  logic [N-1:0] isr,
  input  logic         smm,
  output logic [N-1:0] elig
);
  logic [N-1:0] blk_prefix;

  for (genvar j = 0; j < N; j++) begin : g_lvl
    if (j == 0) begin : g_first
      assign blk_prefix[j] = isr[j];
    end else begin : g_rest
      assign blk_prefix[j] = blk_prefix[j-1] | isr[j];
    end
    assign elig[j] = irr[j] & ~imr[j] & (smm ? ~isr[j] : ~blk_prefix[j]);
  end
endmodule

// File: rtl/irq_cmd_dec.sv
module irq_cmd_dec
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          wr_cmd,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  input  logic          poll_take,
  output logic [N-1:0]  imr,
  output logic          smm,
  output logic          poll,
  output rsel_e         rsel,
  output logic          eoi
);
  logic [N-1:0] imr_q, imr_d;
  logic         smm_q, smm_d;
  logic         poll_q, poll_d;
  rsel_e        rsel_q, rsel_d;
  logic         unused_bits;

  assign unused_bits = ^wdata;

  always_comb begin
    imr_d  = imr_q;
    smm_d  = smm_q;
    poll_d = poll_q;
    rsel_d = rsel_q;
    if (wr_mask) imr_d = wdata[N-1:0];
    if (poll_take) poll_d = 1'b0;
    if (wr_cmd) begin
      if (wdata[CMD_SMM_EN]) smm_d = wdata[CMD_SMM_VAL];
      if (wdata[CMD_POLL]) poll_d = 1'b1;
      if (wdata[CMD_RSEL_EN]) rsel_d = rsel_e'(wdata[CMD_RSEL]);
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      imr_q  <= '0;
      smm_q  <= 1'b0;
      poll_q <= 1'b0;
      rsel_q <= RSEL_REQ;
    end else begin
      imr_q  <= imr_d;
      smm_q  <= smm_d;
      poll_q <= poll_d;
      rsel_q <= rsel_d;
    end
  end

  assign imr  = imr_q;
  assign smm  = smm_q;
  assign poll = poll_q;
  assign rsel = rsel_q;
  assign eoi  = wr_cmd & wdata[CMD_EOI];

  // R5: enable bit set loads the mode from the value bit
  a_r5_smm_load: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_cmd && wdata[CMD_SMM_EN]) |=> (smm_q == $past(wdata[CMD_SMM_VAL])));

  // R8: a poll read without a new poll command disarms
  a_r8_poll_disarm: assert property (@(posedge clk) disable iff (!srst_n)
    (poll_take && !(wr_cmd && wdata[CMD_POLL])) |=> !poll_q);
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic          rd,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [N-1:0]  irq_in,
  input  logic          ack,
  output logic          intr
);
  localparam int LW = (N > 1) ? $clog2(N) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  logic          wr_cmd, wr_mask, rd_stb, poll_take;
  logic [N-1:0]  imr, elig, eoi_src;
  logic          smm, poll, eoi;
  rsel_e         rsel;
  logic          win_valid, eoi_valid;
  logic [LW-1:0] win_idx, eoi_idx;
  logic [N-1:0]  irr_q, irr_d, isr_q, isr_d, set_vec, clr_vec;

  assign wr_cmd    = cs & wr & ~addr;
  assign wr_mask   = cs & wr & addr;
  assign rd_stb    = cs & rd;
  assign poll_take = rd_stb & poll;

  irq_cmd_dec #(.N(N), .DW(DW)) u_cmd (
    .clk       (clk),
    .srst_n    (srst_n),
    .wr_cmd    (wr_cmd),
    .wr_mask   (wr_mask),
    .wdata     (wdata),
    .poll_take (poll_take),
    .imr       (imr),
    .smm       (smm),
    .poll      (poll),
    .rsel      (rsel),
    .eoi       (eoi)
  );

  irq_elig #(.N(N)) u_elig (
    .irr  (irr_q),
    .imr  (imr),
    .isr  (isr_q),
    .smm  (smm),
    .elig (elig)
  );

  irq_prio_enc #(.N(N)) u_win (
    .vec   (elig),
    .valid (win_valid),
    .idx   (win_idx)
  );

  assign eoi_src = smm ? (isr_q & ~imr) : isr_q;

  irq_prio_enc #(.N(N)) u_eoi (
    .vec   (eoi_src),
    .valid (eoi_valid),
    .idx   (eoi_idx)
  );

  // next state
  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    if ((ack | poll_take) & win_valid) set_vec[win_idx] = 1'b1;
    if (eoi & eoi_valid)               clr_vec[eoi_idx] = 1'b1;
    isr_d = (isr_q & ~clr_vec) | set_vec;
    irr_d = poll ? irr_q : irq_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      if (poll) begin
        rdata[DW-1]   = win_valid;
        rdata[LW-1:0] = win_valid ? win_idx : '0;
      end else if (addr) begin
        rdata[N-1:0] = imr;
      end else if (rsel == RSEL_SVC) begin
        rdata[N-1:0] = isr_q;
      end else begin
        rdata[N-1:0] = irr_q;
      end
    end
  end

  assign intr = win_valid;

  // R3: acknowledge sets the in-service bit of the winner
  a_r3_ack_sets: assert property (@(posedge clk) disable iff (!srst_n)
    (ack && win_valid) |=> isr_q[$past(win_idx)]);

  // R9: request register held while a poll is armed
  a_r9_frozen: assert property (@(posedge clk) disable iff (!srst_n)
    poll |=> $stable(irr_q));

  // R2: interrupt needs an unmasked request
  a_r2_unmasked: assert property (@(posedge clk) disable iff (!srst_n)
    intr |-> ((irr_q & ~imr) != '0));

  // R10: end-of-interrupt removes exactly one in-service bit
  a_r10_eoi_one: assert property (@(posedge clk) disable iff (!srst_n)
    (eoi && !ack && !poll_take && (eoi_src != '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));
endmodule

// File: tb/irq_resolver_tb_top.sv
module irq_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, rd = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, rdata, irq_in = '0;
  logic       intr;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  irq_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .ack(ack), .intr(intr)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0; wdata = '0;
  endtask

  task automatic rd_reg(input logic a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    #2 d = rdata;
    @(negedge clk); cs = 0; rd = 0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 intr", {7'b0, intr}, 8'h00);
    rd_reg(1'b0, d); check("R1 request", d, 8'h00);
    rd_reg(1'b1, d); check("R1 mask", d, 8'h00);
    wr_reg(1'b0, 8'h03);
    rd_reg(1'b0, d); check("R1 in-service", d, 8'h00);
    wr_reg(1'b0, 8'h02);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr_reg(1'b1, 8'h0F);
    rd_reg(1'b1, d); check("R2 mask readback", d, 8'h0F);
    set_irq(8'h08);
    check("R2 masked no intr", {7'b0, intr}, 8'h00);
    set_irq(8'h30);
    check("R2 unmasked intr", {7'b0, intr}, 8'h01);
    rd_reg(1'b0, d); check("R11 request sampled", d, 8'h30);
    wr_reg(1'b1, 8'h00);
  endtask

  task automatic t_normal();
    logic [7:0] d;
    wr_reg(1'b0, 8'h03);
    pulse_ack();
    rd_reg(1'b0, d); check("R3 ack sets level 4", d, 8'h10);
    check("R4 blocked same and lower", {7'b0, intr}, 8'h00);
    set_irq(8'h34);
    check("R4 higher passes", {7'b0, intr}, 8'h01);
    pulse_ack();
    rd_reg(1'b0, d); check("R3 nested level 2", d, 8'h14);
    wr_reg(1'b0, 8'h80);
    rd_reg(1'b0, d); check("R10 eoi clears level 2", d, 8'h10);
    wr_reg(1'b0, 8'h80);
    rd_reg(1'b0, d); check("R10 eoi clears level 4", d, 8'h00);
    set_irq(8'h00);
    check("R11 intr falls", {7'b0, intr}, 8'h00);
  endtask

  task automatic t_smm();
    logic [7:0] d;
    wr_reg(1'b0, 8'h60);
    set_irq(8'h30);
    pulse_ack();
    check("R6 lower level passes", {7'b0, intr}, 8'h01);
    pulse_ack();
    rd_reg(1'b0, d); check("R6 both in service", d, 8'h30);
    check("R6 own bit blocks", {7'b0, intr}, 8'h00);
    wr_reg(1'b1, 8'h20);
    set_irq(8'h70);
    check("R6 level 6 passes", {7'b0, intr}, 8'h01);
    pulse_ack();
    rd_reg(1'b0, d); check("R6 level 6 taken", d, 8'h70);
    wr_reg(1'b0, 8'h80);
    rd_reg(1'b0, d); check("R10 smm eoi level 4", d, 8'h60);
    wr_reg(1'b0, 8'h80);
    rd_reg(1'b0, d); check("R10 smm skips masked", d, 8'h20);
    wr_reg(1'b1, 8'h00);
    set_irq(8'h80);
    check("R6 below in-service", {7'b0, intr}, 8'h01);
    wr_reg(1'b0, 8'h20);
    check("R5 enable clear keeps mode", {7'b0, intr}, 8'h01);
    wr_reg(1'b0, 8'h40);
    check("R5 leave mode blocks", {7'b0, intr}, 8'h00);
    wr_reg(1'b0, 8'h80);
    check("R10 normal eoi unblocks", {7'b0, intr}, 8'h01);
    set_irq(8'h00);
  endtask

  task automatic t_poll();
    logic [7:0] d;
    wr_reg(1'b0, 8'h02);
    set_irq(8'h48);
    wr_reg(1'b0, 8'h10);
    set_irq(8'h01);
    rd_reg(1'b0, d); check("R7 R9 poll byte frozen", d, 8'h83);
    rd_reg(1'b0, d); check("R8 disarmed request read", d, 8'h01);
    wr_reg(1'b0, 8'h03);
    rd_reg(1'b0, d); check("R7 poll sets in-service", d, 8'h08);
    wr_reg(1'b0, 8'h80);
    set_irq(8'h00);
    wr_reg(1'b0, 8'h10);
    rd_reg(1'b1, d); check("R7 empty poll byte", d, 8'h00);
    rd_reg(1'b0, d); check("R7 empty poll no set", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mask();
    t_normal();
    t_smm();
    t_poll();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got=%h exp=%h", 8'h00, 8'h01);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule